// File: doc/BRIEF.md
# UART Receive Queue with Character Timeout

This block holds received characters for a 16550-style serial port between the deserializer and the host's reads. In queued mode, bytes go into a 16-entry circular buffer. A write to the control register sets the trigger level and the mode, and it can flush the queues. A full queue never loses data that is already stored: the newest byte is dropped instead, and the overrun flag is raised. In single-register mode there is one holding register, and a new byte replaces it.

A character-time tick drives the idle timer. Every received byte restarts it. A read that leaves data behind also restarts it. If four character times pass with data still queued, the timeout-pending flag is set. A read from the receive buffer clears that flag. The control write also produces a one-cycle flush pulse for a neighbouring transmit queue.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset the fill count, data-ready, overrun, timeout-pending, flush pulse, retained control value and read data are all zero, the block is in single-register mode, and the trigger level is 1.
- R2: In queued mode (control bit 0 set), accepted bytes are read back in arrival order. Each accepted byte raises the fill count by one, up to 16, and each read of a non-empty queue lowers it by one.
- R3: A byte that arrives while 16 bytes are queued, with no read in that cycle, is dropped. The overrun flag is set, the count stays at 16 and the stored bytes are unchanged.
- R4: A read of an empty queue returns 0 and leaves the fill count at 0.
- R5: A receive and a read in the same cycle on a non-empty queue leave the fill count unchanged.
- R6: A control write with bit 0 set loads the trigger level from bits 7:6: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. A control write with bit 0 clear keeps the previous level.
- R7: The retained control value is the written value masked with 0xC9. Bit 1 of the write empties the receive queue for one write only, and it also clears data-ready, timeout-pending and the idle timer.
- R8: A control write that changes bit 0 relative to the retained value empties the receive queue and pulses the flush output for one cycle. A write with bit 2 set also pulses the flush output.
- R9: In queued mode the fourth char_tick after the last restart sets timeout-pending if the queue is not empty. If the queue is empty at that point, timeout-pending is not set.
- R10: A queued-mode read clears timeout-pending. It clears data-ready only when the queue becomes empty; otherwise it restarts the idle timer.
- R11: In single-register mode a byte that arrives while data-ready is set, and no read happens in that cycle, sets overrun and replaces the held byte. A read clears data-ready.
- R12: A status-read strobe clears the overrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| rd_strobe | input | 1 | Host reads the receive buffer |
| stat_rd | input | 1 | Host reads line status (clears overrun) |
| char_tick | input | 1 | One pulse per character time |
| ctl_we | input | 1 | Control register write |
| ctl_wdata | input | 8 | Control register write value |
| rd_data | output | 8 | Value a read returns this cycle |
| data_ready | output | 1 | Received data available |
| overrun | output | 1 | A byte was lost or overwritten |
| fill_count | output | 5 | Bytes queued |
| trig_level | output | 5 | Selected trigger level in bytes |
| timeout_pend | output | 1 | Idle timeout with data queued |
| fifo_on | output | 1 | Queued mode active |
| ctl_state | output | 8 | Retained control bits |
| tx_flush | output | 1 | One-cycle transmit-queue flush pulse |

## Verification
The bench writes all 256 control values in sequence. This separates the masked retention, the trigger decode and the hold-on-disable behaviour, and every change of bit 0 must show up as a flush pulse. A fill with a distinct byte pattern followed by a seventeenth byte tells dropping apart from overwriting, and reading the queue to empty and one read past it shows both the data-ready rule and the zero read. Tick sequences of three and four ticks around receives and reads, with and without data left behind, show where the timer restarts and when it stays silent. A short single-register run checks replacement with overrun.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
    localparam int FCR_EN_BIT    = 0;
    localparam int FCR_RXRST_BIT = 1;
    localparam int FCR_TXRST_BIT = 2;
    localparam logic [7:0] FCR_KEEP_MASK = 8'hC9;
    localparam int TRIG_SEL0 = 1;
    localparam int TRIG_SEL1 = 4;
    localparam int TRIG_SEL2 = 8;
    localparam int TRIG_SEL3 = 14;
endpackage

// File: rtl/rxq_trig_decode.sv
module rxq_trig_decode #(
    parameter int CW = 5
) (
    input  logic [1:0]    sel,
    output logic [CW-1:0] level
);
    import uart_rxq_pkg::*;
    always_comb begin
        unique case (sel)
            2'd0:    level = CW'(TRIG_SEL0);
            2'd1:    level = CW'(TRIG_SEL1);
            2'd2:    level = CW'(TRIG_SEL2);
            default: level = CW'(TRIG_SEL3);
        endcase
    end
endmodule

// File: rtl/rxq_mem.sv
module rxq_mem #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [PW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end
    assign rdata = mem[raddr];
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
    parameter int DW         = 8,
    parameter int DEPTH      = 16,
    parameter int TOUT_CHARS = 4,
    localparam int PW        = $clog2(DEPTH),
    localparam int CW        = $clog2(DEPTH + 1),
    localparam int TW        = $clog2(TOUT_CHARS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic          rd_strobe,
    input  logic          stat_rd,
    input  logic          char_tick,
    input  logic          ctl_we,
    input  logic [7:0]    ctl_wdata,
    output logic [DW-1:0] rd_data,
    output logic          data_ready,
    output logic          overrun,
    output logic [CW-1:0] fill_count,
    output logic [CW-1:0] trig_level,
    output logic          timeout_pend,
    output logic          fifo_on,
    output logic [7:0]    ctl_state,
    output logic          tx_flush
);
    import uart_rxq_pkg::*;

    typedef struct packed {
        logic [PW-1:0] head;
        logic [PW-1:0] tail;
        logic [CW-1:0] cnt;
        logic          dr;
        logic          ovr;
        logic          pend;
        logic          armed;
        logic [TW-1:0] tcnt;
        logic [7:0]    ctl;
        logic [CW-1:0] trig;
        logic [DW-1:0] hold;
        logic          txf;
    } rxq_state_t;

    rxq_state_t s_d, s_q;

    logic          push, pop;
    logic [DW-1:0] mem_rdata;
    logic [CW-1:0] dec_level;
    logic [7:0]    ctl_eff;

    rxq_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (push),
        .waddr (s_q.head),
        .wdata (rx_byte),
        .raddr (s_q.tail),
        .rdata (mem_rdata)
    );

    rxq_trig_decode #(.CW(CW)) u_dec (
        .sel   (ctl_wdata[7:6]),
        .level (dec_level)
    );

    always_comb begin
        s_d     = s_q;
        s_d.txf = 1'b0;
        push    = 1'b0;
        pop     = 1'b0;
        ctl_eff = ctl_wdata;

        if (stat_rd) s_d.ovr = 1'b0;

        if (s_q.ctl[FCR_EN_BIT]) begin
            // queued mode
            pop  = rd_strobe && (s_q.cnt != '0);
            push = rx_valid && ((s_q.cnt < CW'(DEPTH)) || pop);
            if (rx_valid && !push) s_d.ovr = 1'b1;
            if (push) s_d.head = (s_q.head == PW'(DEPTH - 1)) ? '0 : s_q.head + 1'b1;
            if (pop)  s_d.tail = (s_q.tail == PW'(DEPTH - 1)) ? '0 : s_q.tail + 1'b1;
            s_d.cnt = s_q.cnt + CW'(push) - CW'(pop);

            if (rx_valid)                          s_d.dr = 1'b1;
            else if (rd_strobe && s_d.cnt == '0)   s_d.dr = 1'b0;

            if (rd_strobe) s_d.pend = 1'b0;
            if (rx_valid || (rd_strobe && s_d.cnt != '0)) begin
                s_d.armed = 1'b1;
                s_d.tcnt  = '0;
            end else if (s_q.armed && char_tick) begin
                if (s_q.tcnt == TW'(TOUT_CHARS - 1)) begin
                    s_d.armed = 1'b0;
                    s_d.tcnt  = '0;
                    if (s_d.cnt != '0) s_d.pend = 1'b1;
                end else begin
                    s_d.tcnt = s_q.tcnt + 1'b1;
                end
            end
        end else begin
            // single-register mode
            if (rx_valid) begin
                if (s_q.dr && !rd_strobe) s_d.ovr = 1'b1;
                s_d.hold = rx_byte;
                s_d.dr   = 1'b1;
            end else if (rd_strobe) begin
                s_d.dr = 1'b0;
            end
        end

        if (ctl_we) begin
            if (ctl_wdata[FCR_EN_BIT] != s_q.ctl[FCR_EN_BIT]) begin
                ctl_eff[FCR_RXRST_BIT] = 1'b1;
                ctl_eff[FCR_TXRST_BIT] = 1'b1;
            end
            if (ctl_eff[FCR_RXRST_BIT]) begin
                s_d.head  = '0;
                s_d.tail  = '0;
                s_d.cnt   = '0;
                s_d.dr    = 1'b0;
                s_d.pend  = 1'b0;
                s_d.armed = 1'b0;
                s_d.tcnt  = '0;
            end
            if (ctl_eff[FCR_TXRST_BIT]) s_d.txf = 1'b1;
            if (ctl_eff[FCR_EN_BIT])    s_d.trig = dec_level;
            s_d.ctl = ctl_eff & FCR_KEEP_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.trig <= CW'(1);
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data      = s_q.ctl[FCR_EN_BIT] ? ((s_q.cnt != '0) ? mem_rdata : '0) : s_q.hold;
    assign data_ready   = s_q.dr;
    assign overrun      = s_q.ovr;
    assign fill_count   = s_q.cnt;
    assign trig_level   = s_q.trig;
    assign timeout_pend = s_q.pend;
    assign fifo_on      = s_q.ctl[FCR_EN_BIT];
    assign ctl_state    = s_q.ctl;
    assign tx_flush     = s_q.txf;
endmodule

// File: rtl/uart_rx_queue_chk.sv
module uart_rx_queue_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic          rd_strobe,
    input logic          ctl_we,
    input logic [7:0]    ctl_wdata,
    input logic          data_ready,
    input logic          overrun,
    input logic [CW-1:0] fill_count,
    input logic [CW-1:0] trig_level,
    input logic          timeout_pend,
    input logic          fifo_on,
    input logic [7:0]    ctl_state
);
    // R2
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CW'(DEPTH));

    // R3
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_on && fill_count == CW'(DEPTH) && rx_valid && !rd_strobe && !ctl_we)
        |=> (overrun && fill_count == CW'(DEPTH)));

    // R5
    push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_on && rx_valid && rd_strobe && fill_count != '0 && !ctl_we)
        |=> (fill_count == $past(fill_count)));

    // R6
    trig_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_level == CW'(1) || trig_level == CW'(4) || trig_level == CW'(8) || trig_level == CW'(14)));

    // R7
    ctl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> (ctl_state == ($past(ctl_wdata) & 8'hC9)));

    // R9
    pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_pend) |-> (fill_count != '0));

    // R10
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_on && rd_strobe && !ctl_we) |=> !timeout_pend);

    // R10
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_on && fill_count != '0) |-> data_ready);
endmodule

bind uart_rx_queue uart_rx_queue_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .rd_strobe    (rd_strobe),
    .ctl_we       (ctl_we),
    .ctl_wdata    (ctl_wdata),
    .data_ready   (data_ready),
    .overrun      (overrun),
    .fill_count   (fill_count),
    .trig_level   (trig_level),
    .timeout_pend (timeout_pend),
    .fifo_on      (fifo_on),
    .ctl_state    (ctl_state)
);

// File: tb/uart_rx_queue_test.sv
module uart_rx_queue_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_valid, rd_strobe, stat_rd, char_tick, ctl_we;
    logic [7:0] rx_byte, ctl_wdata;
    logic [7:0] rd_data, ctl_state;
    logic       data_ready, overrun, timeout_pend, fifo_on, tx_flush;
    logic [4:0] fill_count, trig_level;

    int vecs = 0;
    int bad  = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    uart_rx_queue uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rd_strobe(rd_strobe), .stat_rd(stat_rd), .char_tick(char_tick),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .rd_data(rd_data),
        .data_ready(data_ready), .overrun(overrun), .fill_count(fill_count),
        .trig_level(trig_level), .timeout_pend(timeout_pend), .fifo_on(fifo_on),
        .ctl_state(ctl_state), .tx_flush(tx_flush)
    );

    task automatic chk(input string req, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rx_valid = 0; rx_byte = 0; rd_strobe = 0; stat_rd = 0;
        char_tick = 0; ctl_we = 0; ctl_wdata = 0;
    endtask

    task automatic finish_cycle();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_rx(input logic [7:0] b);
        rx_valid = 1; rx_byte = b; finish_cycle();
    endtask

    task automatic do_rd();
        rd_strobe = 1; finish_cycle();
    endtask

    task automatic do_ctl(input logic [7:0] v);
        ctl_we = 1; ctl_wdata = v; finish_cycle();
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            char_tick = 1; finish_cycle();
        end
    endtask

    function automatic int trig_of(input int sel);
        case (sel)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic int pat(input int i);
        return (i * 37 + 11) & 255;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            vecs++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end

    initial begin
        int prev_fe;
        int prev_trig;
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 count", fill_count, 0);
        chk("R1 ready", data_ready, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 pend", timeout_pend, 0);
        chk("R1 trig", trig_level, 1);
        chk("R1 ctl", ctl_state, 0);
        chk("R1 mode", fifo_on, 0);
        chk("R1 rd_data", rd_data, 0);
        chk("R1 flush", tx_flush, 0);

        // R11 single-register mode
        do_rx(8'h5A);
        chk("R11 ready", data_ready, 1);
        chk("R11 data", rd_data, 8'h5A);
        chk("R11 no ovr", overrun, 0);
        do_rx(8'hA5);
        chk("R11 ovr", overrun, 1);
        chk("R11 replaced", rd_data, 8'hA5);
        do_rd();
        chk("R11 read clears", data_ready, 0);
        stat_rd = 1; finish_cycle();
        chk("R12 clear", overrun, 0);

        // R6 R7 R8 sweep all control values
        prev_fe = 0;
        prev_trig = 1;
        for (int v = 0; v < 256; v++) begin
            int fe;
            int exp_trig;
            int exp_flush;
            fe = v & 1;
            exp_trig = fe ? trig_of(v >> 6) : prev_trig;
            exp_flush = ((fe != prev_fe) || ((v >> 2) & 1)) ? 1 : 0;
            do_ctl(8'(v));
            chk("R7 retained", ctl_state, v & 8'hC9);
            chk("R6 trigger", trig_level, exp_trig);
            chk("R8 flush pulse", tx_flush, exp_flush);
            prev_fe = fe;
            prev_trig = exp_trig;
        end
        @(negedge clk);
        chk("R8 pulse ends", tx_flush, 0);
        do_ctl(8'h41);
        chk("R6 sel01", trig_level, 4);

        // R2 R3 fill to full and past
        for (int i = 0; i < 16; i++) begin
            do_rx(8'(pat(i)));
            chk("R2 count up", fill_count, i + 1);
        end
        chk("R2 ready", data_ready, 1);
        do_rx(8'hEE);
        chk("R3 overrun", overrun, 1);
        chk("R3 count", fill_count, 16);
        stat_rd = 1; finish_cycle();
        chk("R12 clear", overrun, 0);
        for (int i = 0; i < 16; i++) begin
            chk("R3 R2 order", rd_data, pat(i));
            do_rd();
            chk("R2 count down", fill_count, 15 - i);
            chk("R10 ready", data_ready, (i == 15) ? 0 : 1);
        end
        // R4 empty read
        chk("R4 data", rd_data, 0);
        do_rd();
        chk("R4 count", fill_count, 0);
        chk("R4 data after", rd_data, 0);

        // R5 simultaneous push and pop
        do_rx(8'h10); do_rx(8'h20); do_rx(8'h30);
        rx_valid = 1; rx_byte = 8'h40; rd_strobe = 1; finish_cycle();
        chk("R5 count", fill_count, 3);
        chk("R5 head", rd_data, 8'h20);
        do_rd(); chk("R5 order", rd_data, 8'h30);
        do_rd(); chk("R5 order", rd_data, 8'h40);
        do_rd(); chk("R5 empty", fill_count, 0);

        // R9 R10 timeout
        do_rx(8'h77); do_rx(8'h78);
        do_ticks(3);
        chk("R9 not yet", timeout_pend, 0);
        do_ticks(1);
        chk("R9 fires", timeout_pend, 1);
        do_rd();
        chk("R10 pend clr", timeout_pend, 0);
        chk("R10 count", fill_count, 1);
        chk("R10 ready kept", data_ready, 1);
        do_ticks(3);
        chk("R10 restarted", timeout_pend, 0);
        do_ticks(1);
        chk("R9 fires again", timeout_pend, 1);
        do_rd();
        chk("R10 pend clr2", timeout_pend, 0);
        chk("R10 ready clr", data_ready, 0);
        do_ticks(5);
        chk("R9 empty silent", timeout_pend, 0);

        // R7 receive-queue reset bit
        do_rx(8'h01); do_rx(8'h02);
        do_ticks(4);
        chk("R9 pend", timeout_pend, 1);
        do_ctl(8'h03);
        chk("R7 count", fill_count, 0);
        chk("R7 ready", data_ready, 0);
        chk("R7 pend", timeout_pend, 0);
        chk("R7 bit1 not kept", ctl_state, 8'h01);
        chk("R7 no flush", tx_flush, 0);

        // R8 toggle enable off flushes
        do_rx(8'h09); do_rx(8'h0A);
        do_ctl(8'h00);
        chk("R8 count", fill_count, 0);
        chk("R8 flush", tx_flush, 1);
        chk("R8 mode", fifo_on, 0);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule